// File: doc/BRIEF.md
# Even-Ratio Reference Clock Divider

This block sits between a reference oscillator and an external clock pin and produces a slower clock from the reference. The slow clock always has equal high and low times. A 4-bit code N selects the ratio 2×N, so even ratios from 2 to 30 are available. Code 0 switches the output off and parks it at a steady high level.

The divider has two stages. A counter reloads every N reference cycles. A toggle flip-flop changes state each time that counter reaches its last count. The pin carries the complement of the toggle, so every enabled run opens with a high phase and the idle level is high.

The ratio code is latched only at the end of a phase, so a register write made at any time never gives a short pulse. The oscillator-enable input stands for the presence of the reference. While it is low, the divider is held cleared and its output stays high. Reset loads code 4 (divide-by-8) whatever the code input shows.

Top module: `clkout_div`

## Requirements
- R1: For a latched code N in 1..15, every output phase lasts exactly N reference cycles, giving an output period of 2×N cycles.
- R2: The high and low phases of one output period are of equal length (50:50), including at the extreme codes 1 and 15.
- R3: The output is the complement of the toggle stage: its idle level is high, and each enabled run begins with a high phase.
- R4: Code 0 stops the divider at the end of the current phase. From then on the output stays high, with no partial pulse.
- R5: Reset clears the counter and the toggle stage, drives the output high, and latches code 4. The first phase after reset lasts 4 cycles whatever the code input carries.
- R6: The code input is sampled only at the last count of a phase, or while the divider is stopped. A change in mid-phase has no effect on the phase in progress.
- R7: While stopped, a nonzero code N is taken at the next clock edge with the counter at zero. The output then stays high for N more cycles before its first fall, so the first period is complete.
- R8: When osc_en is low, the output is high after the next edge, the counter is cleared and the code is reloaded each cycle. When osc_en returns high, the first phase is high and lasts N cycles.
- R9: The output changes only at the last count of a phase, or to high when osc_en is low. No phase is ever shorter than one reference cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| osc_en | input | 1 | Reference oscillator enable; low means no usable reference |
| div_code | input | CODE_W (4) | Half-ratio code N; ratio is 2×N, 0 disables |
| clk_out | output | 1 | Divided, inverted clock with 50:50 duty |

## Verification
The bench builds the block with its default parameters: a 4-bit code and a reset code of 4. With these values every legal code from 1 to the maximum of 15 can be reached, and so can the zero code. The longest phase is 15 cycles, so short runs cover many full periods at both extremes of the ratio. Because the reset code of 4 differs from the code the bench drives during reset, the bench can show that the first phase after reset comes from the parameter and not from the input.

// File: rtl/ecd_pkg.sv
package ecd_pkg;
  // Default width of the half-ratio code and the code latched at reset.
  localparam int unsigned DEF_CODE_W     = 4;
  localparam int unsigned DEF_RESET_CODE = 4;
endpackage

// File: rtl/ecd_ratio_hold.sv
// Holds the active half-ratio code; reloads only at end of phase or when idle.
module ecd_ratio_hold #(
  parameter int unsigned CODE_W     = ecd_pkg::DEF_CODE_W,
  parameter int unsigned RESET_CODE = ecd_pkg::DEF_RESET_CODE
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tc_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] act_o
);
  logic [CODE_W-1:0] act_q, act_d;
  logic              load_en;

  assign load_en = !run_i || tc_i;

  always_comb begin
    act_d = act_q;
    if (load_en) act_d = code_i;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) act_q <= CODE_W'(RESET_CODE);
    else        act_q <= act_d;
  end

  assign act_o = act_q;
endmodule

// File: rtl/ecd_prescale.sv
// First stage: counts 0..N-1 and flags the last count.
module ecd_prescale #(
  parameter int unsigned CODE_W = ecd_pkg::DEF_CODE_W
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [CODE_W-1:0] ratio_i,
  output logic              tc_o
);
  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic              last;

  assign last = (cnt_q == ratio_i - CODE_W'(1));
  assign tc_o = run_i && last;

  always_comb begin
    if (!run_i)    cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + CODE_W'(1);
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ecd_toggle.sv
// Second stage: divide-by-2 toggle, output is its complement.
module ecd_toggle (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic run_i,
  input  logic tc_i,
  input  logic stop_i,
  output logic out_o
);
  logic tgl_q, tgl_d;

  always_comb begin
    tgl_d = tgl_q;
    if (!run_i)    tgl_d = 1'b0;
    else if (tc_i) tgl_d = stop_i ? 1'b0 : ~tgl_q;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_d;
  end

  assign out_o = ~tgl_q;
endmodule

// File: rtl/clkout_div.sv
module clkout_div #(
  parameter int unsigned CODE_W     = ecd_pkg::DEF_CODE_W,
  parameter int unsigned RESET_CODE = ecd_pkg::DEF_RESET_CODE
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic [CODE_W-1:0] div_code,
  output logic              clk_out
);
  logic [CODE_W-1:0] ratio_act;
  logic              run;
  logic              tc;
  logic              stop_req;

  assign run      = osc_en && (ratio_act != '0);
  assign stop_req = (div_code == '0);

  ecd_ratio_hold #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_hold (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .run_i   (run),
    .tc_i    (tc),
    .code_i  (div_code),
    .act_o   (ratio_act)
  );

  ecd_prescale #(.CODE_W(CODE_W)) u_pre (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .run_i   (run),
    .ratio_i (ratio_act),
    .tc_o    (tc)
  );

  ecd_toggle u_tgl (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .run_i   (run),
    .tc_i    (tc),
    .stop_i  (stop_req),
    .out_o   (clk_out)
  );
endmodule

// File: rtl/ecd_chk.sv
module ecd_chk #(
  parameter int unsigned CODE_W = ecd_pkg::DEF_CODE_W
) (
  input logic              clk_ref,
  input logic              rst_n,
  input logic              osc_en,
  input logic [CODE_W-1:0] div_code,
  input logic              clk_out,
  input logic [CODE_W-1:0] ratio_act,
  input logic              run,
  input logic              tc
);
  assert_osc_off_idle_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !osc_en |=> clk_out);

  assert_edge_at_tc_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(clk_out) |-> ($past(tc) || ($past(!osc_en) && clk_out)));

  assert_code_held_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (run && !tc) |=> $stable(ratio_act));

  assert_zero_stops_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (tc && div_code == '0) |=> (clk_out && ratio_act == '0));

  assert_start_high_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !run |=> clk_out);
endmodule

bind clkout_div ecd_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .osc_en    (osc_en),
  .div_code  (div_code),
  .clk_out   (clk_out),
  .ratio_act (ratio_act),
  .run       (run),
  .tc        (tc)
);

// File: tb/tb_clkout_div.sv
module tb_clkout_div;
  localparam int CW = 4;

  logic          clk_ref = 1'b0;
  logic          rst_n;
  logic          osc_en;
  logic [CW-1:0] div_code;
  logic          clk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state, derived from the requirements.
  int m_act, m_cnt;
  bit m_tgl;

  clkout_div dut (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .div_code (div_code),
    .clk_out  (clk_out)
  );

  always #4 clk_ref = ~clk_ref;

  function automatic bit next_toggle(bit tgl, int code);
    return (code == 0) ? 1'b0 : ~tgl;
  endfunction

  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 4; m_cnt = 0; m_tgl = 1'b0;           // R5
    end else if (!(osc_en && m_act != 0)) begin
      m_cnt = 0; m_tgl = 1'b0; m_act = int'(div_code); // R7, R8
    end else if (m_cnt == m_act - 1) begin
      m_cnt = 0; m_tgl = next_toggle(m_tgl, int'(div_code)); m_act = int'(div_code);
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  // Cycle-by-cycle comparison against the model (R9, R1).
  always @(negedge clk_ref) begin
    if (rst_n === 1'b1 && !done) begin
      checks++;
      if (clk_out !== ~m_tgl) begin
        fails++;
        $display("FAIL R9 t=%0t clk_out actual=%b expected=%b", $time, clk_out, ~m_tgl);
      end
    end
  end

  task automatic check_eq(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_run(output int n);
    logic v;
    v = clk_out;
    n = 1;
    while (n < 200) begin
      @(negedge clk_ref);
      if (clk_out !== v) break;
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_ref);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    bit stayed;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; osc_en = 1'b1; div_code = 4'd3;
    repeat (3) @(negedge clk_ref);
    check_eq(int'(clk_out), 1, "R5 output high in reset");
    rst_n = 1'b1;

    count_run(n); check_eq(n, 4, "R5 first phase uses reset code");
    count_run(n); check_eq(n, 3, "R1 phase after reload");

    div_code = 4'd1;
    count_run(n); check_eq(n, 3, "R6 phase in progress keeps old code");
    count_run(n); check_eq(n, 1, "R1 code 1 phase");
    count_run(n); check_eq(n, 1, "R2 code 1 other phase");

    div_code = 4'd15;
    count_run(n); check_eq(n, 1, "R6 in-progress phase");
    count_run(n); check_eq(n, 15, "R2 code 15 phase a");
    count_run(n); check_eq(n, 15, "R2 code 15 phase b");

    div_code = 4'd0;
    repeat (35) @(negedge clk_ref);
    stayed = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (clk_out !== 1'b1) stayed = 1'b0;
      @(negedge clk_ref);
    end
    check_eq(int'(stayed), 1, "R4 disabled output held high");

    div_code = 4'd5;
    count_run(n); check_eq(n, 6, "R7 restart gives full first high phase");
    count_run(n); check_eq(n, 5, "R7 first low phase");
    count_run(n); check_eq(n, 5, "R3 following high phase");

    osc_en = 1'b0;
    @(negedge clk_ref);
    check_eq(int'(clk_out), 1, "R8 high after oscillator off");
    div_code = 4'd7;
    stayed = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_ref);
      if (clk_out !== 1'b1) stayed = 1'b0;
    end
    check_eq(int'(stayed), 1, "R8 held high while off");
    osc_en = 1'b1;
    count_run(n); check_eq(n, 7, "R8 first phase after return");
    count_run(n); check_eq(n, 7, "R3 low phase after return");

    div_code = 4'd6;
    count_run(n); check_eq(n, 7, "R6 in-progress phase");
    count_run(n); check_eq(n, 6, "R1 code 6");
    repeat (2) @(negedge clk_ref);
    div_code = 4'd2;
    count_run(n); check_eq(n, 4, "R6 mid-phase change ignored");
    count_run(n); check_eq(n, 2, "R6 new code at phase end");

    for (int c = 0; c < 3000; c++) begin
      @(negedge clk_ref);
      if ($urandom_range(39) == 0) div_code = CW'($urandom_range(15));
      if ($urandom_range(299) == 0) osc_en = ~osc_en;
    end
    osc_en = 1'b1;
    repeat (40) @(negedge clk_ref);
    finish_run();
  end
endmodule